// File: doc/BRIEF.md
# Multi-function GPIO pin controller

This block runs five multi-function digital pins. Each pin owns a configuration word that picks its function (plain input, plain output, interrupt output, clock, or one of four alternate signals produced elsewhere in the chip), its direction, an output drive style, a driven level, an input polarity, an optional debounce filter, pull enables and an interrupt mode. For every pin the block produces an output value, an output enable and pull-up/pull-down enables for the pad, so the pad logic itself stays outside.

Each pin's input passes a two-flop synchroniser and then an optional debouncer. The debouncer is a two-state machine per pin: in `DB_STABLE` it holds the accepted value, and the transition *arm* moves it to `DB_PENDING` when the synchronised input differs. In `DB_PENDING` the transition *bounce* returns it to `DB_STABLE` when the input goes back to the held value, and the transition *accept* loads the new value and returns to `DB_STABLE` once enough ticks of the slow `db_tick` strobe have been counted. The filtered value, after the polarity flip, is the pin's condition; it feeds an interrupt status bit that is either sticky on both edges or a live copy of the condition. The unmasked status bits are ORed into `irq`, which a pin can also drive out through its interrupt-output function.

A flat register port with a combinational read gives access to the five configuration words, the status bits, the debounce threshold and the live pin conditions.

Top module: `gpio_pinctrl`

## Requirements
- R1: After reset every configuration word reads 0x808 (input, no pulls, active-high, no debounce, edge mode, masked), status reads 0, the debounce threshold reads 16, and `pad_oe`, `pad_out`, `pad_pu`, `pad_pd` and `irq` are all 0.
- R2: Register addresses 0 to 4 hold the words of pins 1 to 5 with fields fn [2:0], input-direction [3] (1 = input), open-drain [4], level [5], active-low [6], debounce enable [7], pull-up [8], pull-down [9], level interrupt mode [10] (1 = level), mask [11] (1 = masked); address 5 is the status bits [4:0] (write 1 clears), 6 the debounce threshold [7:0], 7 the live conditions [4:0]; a written word reads back unchanged.
- R3: With fn 1, direction output and CMOS drive, the pin is driven with `pad_oe` 1 and `pad_out` equal to the level bit.
- R4: fn 2 drives `irq`, fn 3 drives the pin's `clk_alt` bit, fn 4 to 7 drive bit fn-4 of the pin's nibble of `alt_sig`; fn 0, an input direction, or a code not allowed on the pin (code 7 on pins 3 and 4) leaves `pad_oe` and `pad_out` at 0.
- R5: With open-drain drive, a 0 is driven (`pad_oe` 1, `pad_out` 0) and a 1 releases the pin (`pad_oe` 0).
- R6: Pull-up alone enables `pad_pu`, pull-down alone enables `pad_pd`, and both set enables neither.
- R7: Without debounce, a pin's condition is the pin input XOR the active-low bit and appears at address 7 after the second rising clock edge that samples the new input level.
- R8: With debounce enabled, a new input level is taken only after the threshold count of `db_tick` cycles while it stays different from the held value; a return to the held value restarts the count; thresholds 0 and 1 both accept on the first tick.
- R9: In edge mode a status bit is set by both rising and falling condition changes, stays set, and is cleared by writing 1 to it.
- R10: In level mode a status bit follows the condition one cycle later and writing 1 to it has no effect.
- R11: `irq` is the OR of the status bits whose mask is 0; a masked bit is still visible in the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Read data for `reg_addr`, combinational |
| db_tick | input | 1 | Slow strobe that paces the debouncers |
| pin_in | input | 5 | Pad input levels, asynchronous |
| clk_alt | input | 5 | Per-pin clock for function 3 |
| alt_sig | input | 20 | Four alternate signals per pin, pin 1 in the low nibble |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |
| pad_pu | output | 5 | Pull-up enables |
| pad_pd | output | 5 | Pull-down enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the debounce counter restart: a design that kept its count across a bounce would accept a level after two plus one ticks, and the bench sees the pin flip one tick early. It hits the disallowed code on pins 3 and 4, where a design ignoring the per-pin allowance would drive an alternate signal, and the both-pulls case, where a naive decode would enable both pulls. It checks that the falling edge sets a sticky bit and that level-mode bits ignore the clear write, which a single-edge or always-sticky design would fail, and that a masked bit still shows in status while `irq` stays low.

// File: rtl/gpio_pctl_pkg.sv
package gpio_pctl_pkg;

    localparam int FN_W  = 3;
    localparam int N_FN  = 1 << FN_W;
    localparam int N_ALT = N_FN - 4;

    localparam logic [FN_W-1:0] FN_GPI = 3'd0;
    localparam logic [FN_W-1:0] FN_GPO = 3'd1;
    localparam logic [FN_W-1:0] FN_IRQ = 3'd2;
    localparam logic [FN_W-1:0] FN_CLK = 3'd3;

    typedef struct packed {
        logic            mask;
        logic            lvl_irq;
        logic            pd;
        logic            pu;
        logic            db_en;
        logic            act_low;
        logic            level;
        logic            opendrain;
        logic            is_in;
        logic [FN_W-1:0] fn;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);
    localparam pin_cfg_t CFG_RESET = pin_cfg_t'(12'h808);

    typedef enum logic {
        DB_STABLE  = 1'b0,
        DB_PENDING = 1'b1
    } db_state_t;

endpackage

// File: rtl/gpio_pctl_sync.sv
module gpio_pctl_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_pctl_debounce.sv
module gpio_pctl_debounce
    import gpio_pctl_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    input  logic [CW-1:0] thresh,
    output logic          q
);
    db_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          q_d;
    logic [CW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        st_d    = st_q;
        cnt_d   = cnt_q;
        q_d     = q;
        unique case (st_q)
            DB_STABLE: begin
                if (din != q) begin
                    st_d  = DB_PENDING;
                    cnt_d = '0;
                end
            end
            DB_PENDING: begin
                if (din == q) begin
                    st_d  = DB_STABLE;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, thresh}) begin
                        q_d   = din;
                        st_d  = DB_STABLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc[CW-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DB_STABLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            q     <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            q     <= q_d;
        end
    end

    AST_DB_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q)); // R8

    AST_DB_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (din == q) |=> $stable(q)); // R8
endmodule

// File: rtl/gpio_pctl_pinout.sv
module gpio_pctl_pinout
    import gpio_pctl_pkg::*;
#(
    parameter logic [N_FN-1:0] FN_OK = '1
) (
    input  pin_cfg_t         cfg,
    input  logic             irq,
    input  logic             clk_alt,
    input  logic [N_ALT-1:0] alt,
    output logic             oe,
    output logic             out,
    output logic             pu,
    output logic             pd
);
    logic drive;
    logic val;

    always_comb begin
        unique case (cfg.fn)
            FN_GPI:  val = 1'b0;
            FN_GPO:  val = cfg.level;
            FN_IRQ:  val = irq;
            FN_CLK:  val = clk_alt;
            default: val = alt[cfg.fn[1:0]];
        endcase
    end

    assign drive = !cfg.is_in && (cfg.fn != FN_GPI) && FN_OK[cfg.fn];

    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        if (drive) begin
            if (cfg.opendrain) begin
                oe = !val;
            end else begin
                oe  = 1'b1;
                out = val;
            end
        end
    end

    assign pu = cfg.pu && !cfg.pd;
    assign pd = cfg.pd && !cfg.pu;
endmodule

// File: rtl/gpio_pctl_irq.sv
module gpio_pctl_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] lvl_mode,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat,
    output logic         irq
);
    logic [N-1:0] cond_q;
    logic [N-1:0] stat_d;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (lvl_mode[i]) stat_d[i] = cond[i];
            else             stat_d[i] = (stat[i] && !clr[i]) || (cond[i] != cond_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '0;
            stat   <= '0;
        end else begin
            cond_q <= cond;
            stat   <= stat_d;
        end
    end

    assign irq = |(stat & ~mask);

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g] && !lvl_mode[g] && !clr[g]) |=> stat[g]); // R9
        AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_mode[g] |=> (stat[g] == $past(cond[g]))); // R10
        AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (stat == (1 << g)) && mask[g] |-> !irq); // R11
    end
endmodule

// File: rtl/gpio_pinctrl.sv
module gpio_pinctrl
    import gpio_pctl_pkg::*;
#(
    parameter int                   NPINS     = 5,
    parameter int                   DBW       = 8,
    parameter logic [DBW-1:0]       DB_RESET  = 8'd16,
    parameter logic [NPINS*N_FN-1:0] FN_ALLOW = 40'hFF_7F_7F_FF_FF,
    localparam int                  AW        = $clog2(NPINS + 3),
    localparam int                  DW        = CFG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [AW-1:0]          reg_addr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   db_tick,
    input  logic [NPINS-1:0]       pin_in,
    input  logic [NPINS-1:0]       clk_alt,
    input  logic [NPINS*N_ALT-1:0] alt_sig,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_pu,
    output logic [NPINS-1:0]       pad_pd,
    output logic                   irq
);
    localparam logic [AW-1:0] ADDR_STAT = AW'(NPINS);
    localparam logic [AW-1:0] ADDR_DBT  = AW'(NPINS + 1);
    localparam logic [AW-1:0] ADDR_COND = AW'(NPINS + 2);

    pin_cfg_t         cfg_q [NPINS];
    logic [DBW-1:0]   thresh_q;
    logic [NPINS-1:0] sync_in, filt, cond, lvl_mode, mask, clr, stat;

    // register file
    for (genvar g = 0; g < NPINS; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                cfg_q[g] <= CFG_RESET;
            else if (reg_we && reg_addr == AW'(g))     cfg_q[g] <= pin_cfg_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              thresh_q <= DB_RESET;
        else if (reg_we && reg_addr == ADDR_DBT) thresh_q <= reg_wdata[DBW-1:0];
    end

    assign clr = (reg_we && reg_addr == ADDR_STAT) ? reg_wdata[NPINS-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = cfg_q[i];
        end
        if (reg_addr == ADDR_STAT) reg_rdata = DW'(stat);
        if (reg_addr == ADDR_DBT)  reg_rdata = DW'(thresh_q);
        if (reg_addr == ADDR_COND) reg_rdata = DW'(cond);
    end

    // input path
    gpio_pctl_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_in)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic deb_q;

        gpio_pctl_debounce #(.CW(DBW)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (db_tick),
            .din    (sync_in[g]),
            .thresh (thresh_q),
            .q      (deb_q)
        );

        assign filt[g]     = cfg_q[g].db_en ? deb_q : sync_in[g];
        assign cond[g]     = filt[g] ^ cfg_q[g].act_low;
        assign lvl_mode[g] = cfg_q[g].lvl_irq;
        assign mask[g]     = cfg_q[g].mask;

        gpio_pctl_pinout #(.FN_OK(FN_ALLOW[g*N_FN +: N_FN])) u_out (
            .cfg     (cfg_q[g]),
            .irq     (irq),
            .clk_alt (clk_alt[g]),
            .alt     (alt_sig[g*N_ALT +: N_ALT]),
            .oe      (pad_oe[g]),
            .out     (pad_out[g]),
            .pu      (pad_pu[g]),
            .pd      (pad_pd[g])
        );

        AST_ILLEGAL_FN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !FN_ALLOW[g*N_FN + int'(cfg_q[g].fn)] |-> !pad_oe[g]); // R4
        AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].is_in |-> (!pad_oe[g] && !pad_out[g])); // R4
        AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[g].opendrain |-> !pad_out[g]); // R5
    end

    gpio_pctl_irq #(.N(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond     (cond),
        .lvl_mode (lvl_mode),
        .mask     (mask),
        .clr      (clr),
        .stat     (stat),
        .irq      (irq)
    );
endmodule

// File: tb/gpio_pinctrl_test.sv
`timescale 1ns/1ps
module gpio_pinctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        db_tick = 1'b0;
    logic [4:0]  pin_in = '0;
    logic [4:0]  clk_alt = 5'b10110;
    logic [19:0] alt_sig = 20'h6C3A5;
    logic [4:0]  pad_out, pad_oe, pad_pu, pad_pd;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_pinctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_tick(db_tick),
        .pin_in(pin_in), .clk_alt(clk_alt), .alt_sig(alt_sig),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .irq(irq)
    );

    // {pin[3:0], cfg[15:0], 4'h0, oe, out, pu, pd}
    localparam int NV = 19;
    localparam logic [27:0] VEC [NV] = '{
        28'h0_0821_0_C, 28'h0_0801_0_8, 28'h1_0831_0_0, 28'h1_0811_0_8,
        28'h2_0829_0_0, 28'h3_0803_0_8, 28'h4_0803_0_C, 28'h0_0804_0_C,
        28'h1_0805_0_C, 28'h4_0807_0_8, 28'h1_0807_0_C, 28'h2_0807_0_0,
        28'h3_0807_0_0, 28'h3_0806_0_C, 28'h2_0800_0_0, 28'h0_0908_0_2,
        28'h0_0A08_0_1, 28'h0_0B08_0_0, 28'h2_0802_0_8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [11:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk); db_tick = 1'b1;
        @(negedge clk); db_tick = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [11:0] d;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int p = 0; p < 5; p++) begin
            rd(3'(p), d);
            chk("R1 cfg", 32'(d), 32'h808);
        end
        rd(3'd5, d); chk("R1 status", 32'(d), 0);
        rd(3'd6, d); chk("R1 thresh", 32'(d), 16);
        chk("R1 pads", {pad_oe, pad_out, pad_pu, pad_pd, 11'b0, irq}, 0);

        // output mux, drive style, pulls
        for (int k = 0; k < NV; k++) begin
            int          p;
            logic [11:0] c;
            logic [3:0]  f;
            string       tag;
            p = int'(VEC[k][27:24]);
            c = VEC[k][19:8];
            f = VEC[k][3:0];
            if (c[9] || c[8])               tag = "R6";
            else if (c[4])                  tag = "R5";
            else if (c[2:0] == 3'd1 && !c[3]) tag = "R3";
            else                            tag = "R4";
            wr(3'(p), c);
            chk(tag, {pad_oe[p], pad_out[p], pad_pu[p], pad_pd[p]}, f);
            rd(3'(p), d);
            chk("R2 readback", 32'(d), 32'(c));
        end
        for (int p = 0; p < 5; p++) wr(3'(p), 12'h808);

        // R7 two-edge latency
        @(negedge clk); pin_in[4] = 1'b1;
        @(negedge clk); rd(3'd7, d); chk("R7 one edge", 32'(d[4]), 0);
        @(negedge clk); rd(3'd7, d); chk("R7 two edges", 32'(d[4]), 1);
        pin_in[4] = 1'b0;
        cyc(4);
        wr(3'd5, 12'h01F);

        // R9 edge mode, both transitions, sticky, W1C
        wr(3'd0, 12'h008);
        pin_in[0] = 1'b1; cyc(4);
        rd(3'd5, d); chk("R9 rise", 32'(d), 32'h01);
        chk("R11 irq on", 32'(irq), 1);
        wr(3'd5, 12'h001);
        rd(3'd5, d); chk("R9 clear", 32'(d), 0);
        chk("R11 irq off", 32'(irq), 0);
        pin_in[0] = 1'b0; cyc(4);
        rd(3'd5, d); chk("R9 fall", 32'(d), 32'h01);
        cyc(10);
        rd(3'd5, d); chk("R9 sticky", 32'(d), 32'h01);
        wr(3'd5, 12'h001);

        // R7 polarity, R11 masking
        wr(3'd1, 12'h848);
        rd(3'd7, d); chk("R7 active low", 32'(d[1]), 1);
        wr(3'd5, 12'h002);
        pin_in[1] = 1'b1; cyc(4);
        rd(3'd7, d); chk("R7 active low high in", 32'(d[1]), 0);
        rd(3'd5, d); chk("R11 masked visible", 32'(d), 32'h02);
        chk("R11 masked quiet", 32'(irq), 0);
        wr(3'd1, 12'h048);
        chk("R11 unmasked", 32'(irq), 1);
        wr(3'd5, 12'h002);
        chk("R11 cleared", 32'(irq), 0);

        // R10 level mode
        wr(3'd2, 12'h408);
        pin_in[2] = 1'b1; cyc(4);
        rd(3'd5, d); chk("R10 level set", 32'(d[2]), 1);
        chk("R10 irq", 32'(irq), 1);
        wr(3'd5, 12'h004);
        rd(3'd5, d); chk("R10 clear ignored", 32'(d[2]), 1);
        pin_in[2] = 1'b0; cyc(4);
        rd(3'd5, d); chk("R10 level follows", 32'(d[2]), 0);
        chk("R10 irq drops", 32'(irq), 0);

        // R8 debounce
        wr(3'd6, 12'd3);
        rd(3'd6, d); chk("R2 thresh", 32'(d), 3);
        wr(3'd3, 12'h888);
        pin_in[3] = 1'b1; cyc(4);
        rd(3'd7, d); chk("R8 held", 32'(d[3]), 0);
        tick1(); tick1();
        rd(3'd7, d); chk("R8 two ticks", 32'(d[3]), 0);
        tick1(); cyc(1);
        rd(3'd7, d); chk("R8 accept", 32'(d[3]), 1);
        pin_in[3] = 1'b0; cyc(4);
        tick1(); tick1();
        pin_in[3] = 1'b1; cyc(4);
        pin_in[3] = 1'b0; cyc(4);
        tick1(); tick1();
        rd(3'd7, d); chk("R8 restart", 32'(d[3]), 1);
        tick1(); cyc(1);
        rd(3'd7, d); chk("R8 accept low", 32'(d[3]), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule